// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multicycle Processor

This block produces the control signals for a multicycle processor datapath from a small read-only control store. A 4-bit microaddress register selects one control word. That word drives every datapath control output directly and combinationally. It also carries a 2-bit sequencing code, which decides where the microaddress goes on the next clock edge. The code can return to the fetch word, step to the next word, or jump through one of two lookup tables indexed by the 6-bit instruction opcode.

The control store holds ten words. One is the common fetch step and one is the decode step. The others complete loads, stores, register-to-register operations, conditional branches and jumps. The datapath that the outputs steer is not part of this block, and neither is any writable control store. The current microaddress is brought out so that the microinstruction trace can be observed.

Top module: `microseq_ctrl`

## Requirements
- R1: While `rst_n` is low, the microaddress is 0. After `rst_n` is released it starts at 0 (fetch), and asserting `rst_n` low in the middle of an instruction returns it to 0.
- R2: When the current word's sequencing code is 00, the next microaddress is 0. Words 4, 5, 7, 8 and 9 use this code.
- R3: When the sequencing code is 11, the next microaddress is the current one plus 1. Words 0, 3 and 6 use this code.
- R4: Sequencing code 01 (used by word 1) takes the next address from the first opcode table. Opcode 6'b000000 maps to 6, 6'b100011 and 6'b101011 map to 2, 6'b000100 maps to 8, and 6'b000010 maps to 9.
- R5: Sequencing code 10 (used by word 2) takes the next address from the second opcode table. Opcode 6'b100011 maps to 3 and 6'b101011 maps to 5.
- R6: Every opcode not listed for a table sends that table's lookup to address 0.
- R7: Field encodings: `alu_mode` 00 = add, 01 = subtract, 10 = use the funct field. `src_a_sel` 0 = PC, 1 = register A. `src_b_sel` 00 = register B, 01 = constant 4, 10 = sign-extended immediate, 11 = immediate shifted left by 2. `pc_src` 00 = ALU result, 01 = ALU-out register, 10 = jump target. Word 0 asserts `mem_rd`, `ir_load` and `pc_wr`, with add, PC, constant 4 and `pc_src` 00; every other control is 0.
- R8: Word 1 is add with PC and the shifted immediate, and asserts no write or memory control.
- R9: The load path 0,1,2,3,4,0 works as follows. Word 2 is add with A and the immediate. Word 3 asserts `mem_rd` and `addr_from_aluout`. Word 4 asserts `reg_wr_en` and `wb_from_mem` with `reg_dst_rd` = 0.
- R10: The store path 0,1,2,5,0 works as follows. Word 5 asserts `mem_wr` and `addr_from_aluout` only.
- R11: The register-operation path 0,1,6,7,0 works as follows. Word 6 is funct mode with A and B. Word 7 asserts `reg_wr_en` and `reg_dst_rd` with `wb_from_mem` = 0.
- R12: The branch path 0,1,8,0 works as follows. Word 8 is subtract with A and B, and asserts `pc_wr_if_zero` with `pc_src` 01 and `pc_wr` = 0.
- R13: The jump path 0,1,9,0 works as follows. Word 9 asserts `pc_wr` with `pc_src` 10 and nothing else.
- R14: `mem_rd` and `mem_wr` are never high together, and neither are `pc_wr` and `pc_wr_if_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the held instruction |
| upc | output | 4 | Current microaddress |
| alu_mode | output | 2 | ALU operation class |
| src_a_sel | output | 1 | First ALU operand select |
| src_b_sel | output | 2 | Second ALU operand select |
| reg_wr_en | output | 1 | Register file write enable |
| reg_dst_rd | output | 1 | Destination register is rd (1) or rt (0) |
| wb_from_mem | output | 1 | Write-back data comes from the memory data register |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_from_aluout | output | 1 | Memory address comes from the ALU-out register (1) or the PC (0) |
| ir_load | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_if_zero | output | 1 | PC write when the ALU zero flag is set |
| pc_src | output | 2 | PC next-value select |

## Verification
Each of the five instruction classes is driven from fetch to its return to fetch. The full microaddress trace and the full control vector are checked on every cycle, so a wrong table entry, a wrong sequencing code or a wrong field bit shows up at a specific microaddress. Load and store share decode and the first address step, and only the second table separates them, so running both isolates that table from the first. An unlisted opcode is used at decode, and a listed opcode is switched to an unlisted one after the first lookup. Each table's default entry is therefore checked on its own. A reset in the middle of an instruction checks that the sequencer returns to fetch and does not resume the interrupted path.

// File: rtl/useq_pkg.sv
package useq_pkg;

   // sequencing codes held in each control word
   typedef enum logic [1:0] {
      SEQ_FETCH = 2'b00,
      SEQ_DISP1 = 2'b01,
      SEQ_DISP2 = 2'b10,
      SEQ_NEXT  = 2'b11
   } seq_e;

   // control word stored in the microcode ROM
   typedef struct packed {
      logic [1:0] alu_mode;
      logic       src_a_sel;
      logic [1:0] src_b_sel;
      logic       reg_wr_en;
      logic       reg_dst_rd;
      logic       wb_from_mem;
      logic       mem_rd;
      logic       mem_wr;
      logic       addr_from_aluout;
      logic       ir_load;
      logic       pc_wr;
      logic       pc_wr_if_zero;
      logic [1:0] pc_src;
      seq_e       seq;
   } uword_t;

   // microprogram layout
   localparam int unsigned UA_FETCH  = 0;
   localparam int unsigned UA_DECODE = 1;
   localparam int unsigned UA_MEMADR = 2;
   localparam int unsigned UA_LDRD   = 3;
   localparam int unsigned UA_LDWB   = 4;
   localparam int unsigned UA_STWR   = 5;
   localparam int unsigned UA_ROP    = 6;
   localparam int unsigned UA_RWB    = 7;
   localparam int unsigned UA_BRCMP  = 8;
   localparam int unsigned UA_JMP    = 9;
   localparam int unsigned UA_WORDS  = 10;

   // opcode values
   localparam int unsigned OPC_ROP = 6'b000000;
   localparam int unsigned OPC_LD  = 6'b100011;
   localparam int unsigned OPC_ST  = 6'b101011;
   localparam int unsigned OPC_BEQ = 6'b000100;
   localparam int unsigned OPC_JMP = 6'b000010;

   // first lookup: instruction class entry word
   function automatic int unsigned class_entry(int unsigned op);
      case (op)
         OPC_ROP:        return UA_ROP;
         OPC_LD, OPC_ST: return UA_MEMADR;
         OPC_BEQ:        return UA_BRCMP;
         OPC_JMP:        return UA_JMP;
         default:        return UA_FETCH;
      endcase
   endfunction

   // second lookup: memory access word
   function automatic int unsigned mem_entry(int unsigned op);
      case (op)
         OPC_LD:  return UA_LDRD;
         OPC_ST:  return UA_STWR;
         default: return UA_FETCH;
      endcase
   endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
   import useq_pkg::*;
#(
   parameter int UA_W = 4
) (
   input  logic [UA_W-1:0] addr,
   output uword_t          word
);

   initial begin
      ua_fits_chk: assert ((1 << UA_W) >= UA_WORDS)
         else $error("microaddress width too small for control store");
   end

   always_comb begin
      word     = '0;
      word.seq = SEQ_FETCH;
      case (addr)
         UA_W'(UA_FETCH): begin
            word.src_b_sel = 2'b01;
            word.mem_rd    = 1'b1;
            word.ir_load   = 1'b1;
            word.pc_wr     = 1'b1;
            word.pc_src    = 2'b00;
            word.seq       = SEQ_NEXT;
         end
         UA_W'(UA_DECODE): begin
            word.src_b_sel = 2'b11;
            word.seq       = SEQ_DISP1;
         end
         UA_W'(UA_MEMADR): begin
            word.src_a_sel = 1'b1;
            word.src_b_sel = 2'b10;
            word.seq       = SEQ_DISP2;
         end
         UA_W'(UA_LDRD): begin
            word.mem_rd           = 1'b1;
            word.addr_from_aluout = 1'b1;
            word.seq              = SEQ_NEXT;
         end
         UA_W'(UA_LDWB): begin
            word.reg_wr_en   = 1'b1;
            word.wb_from_mem = 1'b1;
         end
         UA_W'(UA_STWR): begin
            word.mem_wr           = 1'b1;
            word.addr_from_aluout = 1'b1;
         end
         UA_W'(UA_ROP): begin
            word.alu_mode  = 2'b10;
            word.src_a_sel = 1'b1;
            word.src_b_sel = 2'b00;
            word.seq       = SEQ_NEXT;
         end
         UA_W'(UA_RWB): begin
            word.reg_wr_en  = 1'b1;
            word.reg_dst_rd = 1'b1;
         end
         UA_W'(UA_BRCMP): begin
            word.alu_mode      = 2'b01;
            word.src_a_sel     = 1'b1;
            word.pc_wr_if_zero = 1'b1;
            word.pc_src        = 2'b01;
         end
         UA_W'(UA_JMP): begin
            word.pc_wr  = 1'b1;
            word.pc_src = 2'b10;
         end
         default: word = '0;
      endcase
   end

endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
   import useq_pkg::*;
#(
   parameter int UA_W = 4,
   parameter int OP_W = 6
) (
   input  logic [OP_W-1:0] opcode,
   output logic [UA_W-1:0] class_tgt,
   output logic [UA_W-1:0] mem_tgt
);

   localparam int NOPS = 1 << OP_W;

   initial begin
      op_width_chk: assert (OP_W == 6)
         else $error("opcode width must be 6");
   end

   logic [UA_W-1:0] class_tab [NOPS];
   logic [UA_W-1:0] mem_tab   [NOPS];

   for (genvar g = 0; g < NOPS; g++) begin : g_tab
      assign class_tab[g] = UA_W'(class_entry(g));
      assign mem_tab[g]   = UA_W'(mem_entry(g));
   end

   assign class_tgt = class_tab[opcode];
   assign mem_tgt   = mem_tab[opcode];

endmodule

// File: rtl/useq_next.sv
module useq_next
   import useq_pkg::*;
#(
   parameter int UA_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  seq_e            seq,
   input  logic [UA_W-1:0] class_tgt,
   input  logic [UA_W-1:0] mem_tgt,
   output logic [UA_W-1:0] upc
);

   logic [UA_W-1:0] upc_inc;
   logic [UA_W-1:0] upc_nxt;

   assign upc_inc = upc + UA_W'(1);

   always_comb begin
      unique case (seq)
         SEQ_FETCH: upc_nxt = UA_W'(UA_FETCH);
         SEQ_DISP1: upc_nxt = class_tgt;
         SEQ_DISP2: upc_nxt = mem_tgt;
         SEQ_NEXT:  upc_nxt = upc_inc;
         default:   upc_nxt = UA_W'(UA_FETCH);
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upc <= '0;
      else        upc <= upc_nxt;
   end

   // R1
   reset_start_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> upc == '0);

   // R2
   fetch_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq == SEQ_FETCH |=> upc == '0);

   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq == SEQ_NEXT |=> upc == $past(upc) + UA_W'(1));

endmodule

// File: rtl/microseq_ctrl.sv
module microseq_ctrl
   import useq_pkg::*;
#(
   parameter int UA_W = 4,
   parameter int OP_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] opcode,
   output logic [UA_W-1:0] upc,
   output logic [1:0]      alu_mode,
   output logic            src_a_sel,
   output logic [1:0]      src_b_sel,
   output logic            reg_wr_en,
   output logic            reg_dst_rd,
   output logic            wb_from_mem,
   output logic            mem_rd,
   output logic            mem_wr,
   output logic            addr_from_aluout,
   output logic            ir_load,
   output logic            pc_wr,
   output logic            pc_wr_if_zero,
   output logic [1:0]      pc_src
);

   uword_t          word;
   logic [UA_W-1:0] class_tgt;
   logic [UA_W-1:0] mem_tgt;

   useq_next #(.UA_W(UA_W)) u_next (
      .clk       (clk),
      .rst_n     (rst_n),
      .seq       (word.seq),
      .class_tgt (class_tgt),
      .mem_tgt   (mem_tgt),
      .upc       (upc)
   );

   useq_store #(.UA_W(UA_W)) u_store (
      .addr (upc),
      .word (word)
   );

   useq_dispatch #(.UA_W(UA_W), .OP_W(OP_W)) u_disp (
      .opcode    (opcode),
      .class_tgt (class_tgt),
      .mem_tgt   (mem_tgt)
   );

   assign alu_mode         = word.alu_mode;
   assign src_a_sel        = word.src_a_sel;
   assign src_b_sel        = word.src_b_sel;
   assign reg_wr_en        = word.reg_wr_en;
   assign reg_dst_rd       = word.reg_dst_rd;
   assign wb_from_mem      = word.wb_from_mem;
   assign mem_rd           = word.mem_rd;
   assign mem_wr           = word.mem_wr;
   assign addr_from_aluout = word.addr_from_aluout;
   assign ir_load          = word.ir_load;
   assign pc_wr            = word.pc_wr;
   assign pc_wr_if_zero    = word.pc_wr_if_zero;
   assign pc_src           = word.pc_src;

   // R4
   class_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_DECODE) && opcode == OP_W'(OPC_LD))
      |=> upc == UA_W'(UA_MEMADR));

   // R4
   class_rop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_DECODE) && opcode == OP_W'(OPC_ROP))
      |=> upc == UA_W'(UA_ROP));

   // R5
   mem_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (upc == UA_W'(UA_MEMADR) && opcode == OP_W'(OPC_ST))
      |=> upc == UA_W'(UA_STWR));

   // R14
   mem_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R14
   pc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pc_wr && pc_wr_if_zero));

   // R12
   branch_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_wr_if_zero |-> pc_src == 2'b01);

endmodule

// File: tb/sim_microseq_ctrl.sv
module sim_microseq_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] opcode = 6'd0;
   logic [3:0] upc;
   logic [1:0] alu_mode, src_b_sel, pc_src;
   logic       src_a_sel, reg_wr_en, reg_dst_rd, wb_from_mem;
   logic       mem_rd, mem_wr, addr_from_aluout, ir_load, pc_wr, pc_wr_if_zero;

   int n_chk = 0;
   int n_bad = 0;

   // expected control vectors built from the field encodings
   localparam logic [15:0] V_FETCH = 16'h0898;
   localparam logic [15:0] V_DEC   = 16'h1800;
   localparam logic [15:0] V_MADR  = 16'h3000;
   localparam logic [15:0] V_LDRD  = 16'h00A0;
   localparam logic [15:0] V_LDWB  = 16'h0500;
   localparam logic [15:0] V_STWR  = 16'h0060;
   localparam logic [15:0] V_ROP   = 16'hA000;
   localparam logic [15:0] V_RWB   = 16'h0600;
   localparam logic [15:0] V_BR    = 16'h6005;
   localparam logic [15:0] V_JMP   = 16'h000A;

   always #5 clk = ~clk;

   microseq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .upc(upc),
      .alu_mode(alu_mode), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
      .reg_wr_en(reg_wr_en), .reg_dst_rd(reg_dst_rd), .wb_from_mem(wb_from_mem),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_from_aluout(addr_from_aluout),
      .ir_load(ir_load), .pc_wr(pc_wr), .pc_wr_if_zero(pc_wr_if_zero),
      .pc_src(pc_src)
   );

   wire [15:0] ctl = {alu_mode, src_a_sel, src_b_sel, reg_wr_en, reg_dst_rd,
                      wb_from_mem, mem_rd, mem_wr, addr_from_aluout, ir_load,
                      pc_wr, pc_wr_if_zero, pc_src};

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic check(input logic [3:0] ea, input logic [15:0] ev, input string tag);
      n_chk++;
      if (upc !== ea || ctl !== ev) begin
         n_bad++;
         $display("FAIL %s: upc=%0d ctl=%h expected upc=%0d ctl=%h", tag, upc, ctl, ea, ev);
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      check(4'd0, V_FETCH, "R1 reset held");
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      check(4'd0, V_FETCH, "R1 reset released / R7 fetch word");
   endtask

   task automatic t_load();
      opcode = 6'b100011;
      check(4'd0, V_FETCH, "R7 fetch");
      tick(); check(4'd1, V_DEC,  "R3 R8 decode");
      tick(); check(4'd2, V_MADR, "R4 R9 address step");
      tick(); check(4'd3, V_LDRD, "R5 R9 load read");
      tick(); check(4'd4, V_LDWB, "R3 R9 load writeback");
      tick(); check(4'd0, V_FETCH, "R2 load return");
   endtask

   task automatic t_store();
      opcode = 6'b101011;
      tick(); check(4'd1, V_DEC,  "R10 decode");
      tick(); check(4'd2, V_MADR, "R4 R10 address step");
      tick(); check(4'd5, V_STWR, "R5 R10 store write");
      tick(); check(4'd0, V_FETCH, "R2 store return");
   endtask

   task automatic t_rop();
      opcode = 6'b000000;
      tick(); check(4'd1, V_DEC,  "R11 decode");
      tick(); check(4'd6, V_ROP,  "R4 R11 operate");
      tick(); check(4'd7, V_RWB,  "R3 R11 writeback");
      tick(); check(4'd0, V_FETCH, "R2 rop return");
   endtask

   task automatic t_branch();
      opcode = 6'b000100;
      tick(); check(4'd1, V_DEC, "R12 decode");
      tick(); check(4'd8, V_BR,  "R4 R12 compare");
      tick(); check(4'd0, V_FETCH, "R2 branch return");
   endtask

   task automatic t_jump();
      opcode = 6'b000010;
      tick(); check(4'd1, V_DEC, "R13 decode");
      tick(); check(4'd9, V_JMP, "R4 R13 jump");
      tick(); check(4'd0, V_FETCH, "R2 jump return");
   endtask

   task automatic t_unlisted();
      opcode = 6'b111111;
      tick(); check(4'd1, V_DEC, "R6 decode");
      tick(); check(4'd0, V_FETCH, "R6 first table default");
      opcode = 6'b100011;
      tick(); check(4'd1, V_DEC, "R6 decode again");
      tick(); check(4'd2, V_MADR, "R6 address step");
      @(negedge clk);
      opcode = 6'b000100;
      #2;
      tick(); check(4'd0, V_FETCH, "R6 second table default");
   endtask

   task automatic t_mid_reset();
      opcode = 6'b000000;
      tick(); check(4'd1, V_DEC, "R1 decode before reset");
      tick(); check(4'd6, V_ROP, "R1 operate before reset");
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check(4'd0, V_FETCH, "R1 mid reset");
      @(negedge clk);
      rst_n = 1'b1;
      tick(); check(4'd1, V_DEC, "R1 restart from fetch");
      tick(); check(4'd6, V_ROP, "R1 restart dispatch");
      tick(); check(4'd7, V_RWB, "R1 restart writeback");
      tick(); check(4'd0, V_FETCH, "R1 restart return");
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_load();
      t_store();
      t_rop();
      t_branch();
      t_jump();
      t_unlisted();
      t_mid_reset();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule